// File: doc/BRIEF.md
# Coalescing Store Buffer with Load Forwarding

This block sits between a core's store port and its data cache. A store hands over an address, a data word and a byte mask and is accepted at once, whether or not the cache would hit. The buffered stores are then written to the cache in the background, in the order they were allocated, through a valid/ready drain port. Meanwhile loads keep running. Each load looks up the buffer in the same cycle as the cache read and gets back a word in which buffered bytes replace the bytes the cache returned.

Each entry holds one word-aligned address, one data word and a valid bit per byte. A store to a word that already has a pending entry, other than the one being offered to the cache, is folded into the youngest such entry. This keeps entries free for other words. A load whose bytes are all found in the buffer is flagged, so the core does not have to wait for a cache miss on that word.

Top module: `wbuf_top`

## Requirements
- R1: After a synchronous active-low reset the buffer is empty: `dr_valid` is 0, `st_ready` is 1 and `ld_buf_mask` is all zero.
- R2: While fewer than DEPTH entries are occupied, `st_ready` is 1 whatever the state of `dr_ready`. A store accepted in one cycle makes `dr_valid` 1 in the next cycle.
- R3: Entries leave through the drain port strictly in allocation order. `dr_addr` is the entry's byte address with its low log2(DW/8) bits zero. `dr_mask` bit i flags byte i, which is `dr_data[8i+7:8i]`. While `dr_valid` is 1 and `dr_ready` is 0, all drain outputs hold.
- R4: An entry is released only in a cycle where `dr_valid` and `dr_ready` are both 1. Occupancy never falls otherwise.
- R5: A store whose word address matches a pending entry other than the oldest one merges into the youngest such entry. Only the bytes set in its mask are overwritten, and the entry's byte mask becomes the union of the two masks.
- R6: The oldest entry, the one on the drain port, is never merged into. A store to its word allocates a new entry.
- R7: With all DEPTH entries occupied, `st_ready` is 0 unless the store can merge under R5, in which case it is 1.
- R8: For each byte i of a load, `ld_data[8i+7:8i]` comes from a pending entry with a matching word address and byte i valid. If there is none, it comes from `ld_cache_data[8i+7:8i]`. `ld_buf_mask` bit i is 1 exactly when the byte came from the buffer.
- R9: When several pending entries supply the same byte, the youngest of them wins.
- R10: `ld_all_buf` is 1 when every byte of the load came from the buffer.
- R11: A store accepted at a clock edge is visible to loads from the following cycle on. An entry stops forwarding once it has been drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Store accepted this cycle when st_valid is high |
| st_addr | input | AW | Store byte address; low bits ignored |
| st_data | input | DW | Store data, byte i in bits 8i+7:8i |
| st_mask | input | DW/8 | Store byte enables |
| ld_addr | input | AW | Load byte address; low bits ignored |
| ld_cache_data | input | DW | Word returned by the cache for the load |
| ld_data | output | DW | Merged load result |
| ld_buf_mask | output | DW/8 | Bytes supplied by the buffer |
| ld_all_buf | output | 1 | Every byte supplied by the buffer |
| dr_valid | output | 1 | Oldest entry offered to the cache |
| dr_ready | input | 1 | Cache accepts the offered entry |
| dr_addr | output | AW | Word-aligned byte address of offered entry |
| dr_data | output | DW | Data of offered entry |
| dr_mask | output | DW/8 | Byte valid bits of offered entry |

## Verification
The hardest situation to reach from the ports is a full buffer where the fate of a new store depends on which entry its word matches. A match on a younger entry must be accepted and merged. A match only on the oldest entry, the one sitting on the drain port, must stall. The stimulus holds `dr_ready` low, fills every entry with distinct words and then probes the store port with the oldest word, a middle word and an unseen word. The stall states are then observed, and the merge is confirmed by the byte mask that emerges at the drain port. A second hard case is overlapping entries for one word, which only arise because the oldest entry cannot be merged into. It is built by storing twice to the word at the head and then merging a third store into the younger copy.

// File: rtl/wbuf_pkg.sv
// Package: default geometry of the store buffer.
// Assumes: word width is a whole number of bytes, depth a power of two >= 2.
package wbuf_pkg;
    parameter int WB_DEPTH = 4;
    parameter int WB_AW    = 32;
    parameter int WB_DW    = 32;
endpackage

// File: rtl/wbuf_order_ctl.sv
// Circular-queue pointers for the store buffer: head is the oldest entry,
// tail the next free slot, count the number occupied.
// Assumes: push is never raised when full and pop never when empty.
module wbuf_order_ctl #(
    parameter int DEPTH = 4,
    localparam int PTRW = $clog2(DEPTH),
    localparam int CW   = PTRW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic            pop,
    output logic [PTRW-1:0] head,
    output logic [PTRW-1:0] tail,
    output logic [CW-1:0]   count
);
    // Advance pointers and occupancy on allocation and release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            head  <= head + PTRW'(pop);
            tail  <= tail + PTRW'(push);
            count <= count + CW'(push) - CW'(pop);
        end
    end
endmodule

// File: rtl/wbuf_coalesce_find.sv
// Finds the youngest pending entry, excluding the oldest one, whose word
// address equals the incoming store's word address.
// Assumes: entries at ages 0..count-1 counted from head are occupied.
module wbuf_coalesce_find #(
    parameter int DEPTH = 4,
    parameter int WAW   = 30,
    localparam int PTRW = $clog2(DEPTH),
    localparam int CW   = PTRW + 1
) (
    input  logic [WAW-1:0]            st_waddr,
    input  logic [DEPTH-1:0][WAW-1:0] ent_waddr,
    input  logic [PTRW-1:0]           head,
    input  logic [CW-1:0]             count,
    output logic                      hit,
    output logic [PTRW-1:0]           idx
);
    logic [PTRW-1:0] slot;

    // Scan from second-oldest to youngest; the last match wins.
    always_comb begin
        hit  = 1'b0;
        idx  = '0;
        slot = '0;
        for (int k = 1; k < DEPTH; k++) begin
            slot = head + PTRW'(k);
            if ((CW'(k) < count) && (ent_waddr[slot] == st_waddr)) begin
                hit = 1'b1;
                idx = slot;
            end
        end
    end
endmodule

// File: rtl/wbuf_load_merge.sv
// Builds a load result byte by byte: pending buffered bytes override the
// cache word, the youngest matching entry taking priority per byte.
// Assumes: entries at ages 0..count-1 counted from head are occupied.
module wbuf_load_merge #(
    parameter int DEPTH = 4,
    parameter int WAW   = 30,
    parameter int NB    = 4,
    localparam int PTRW = $clog2(DEPTH),
    localparam int CW   = PTRW + 1
) (
    input  logic [WAW-1:0]                     ld_waddr,
    input  logic [NB-1:0][7:0]                 cache_data,
    input  logic [DEPTH-1:0][WAW-1:0]          ent_waddr,
    input  logic [DEPTH-1:0][NB-1:0][7:0]      ent_data,
    input  logic [DEPTH-1:0][NB-1:0]           ent_bv,
    input  logic [PTRW-1:0]                    head,
    input  logic [CW-1:0]                      count,
    output logic [NB-1:0][7:0]                 merged,
    output logic [NB-1:0]                      from_buf
);
    logic [PTRW-1:0] slot;

    // Walk oldest to youngest so that younger bytes overwrite older ones.
    always_comb begin
        merged   = cache_data;
        from_buf = '0;
        slot     = '0;
        for (int k = 0; k < DEPTH; k++) begin
            slot = head + PTRW'(k);
            if ((CW'(k) < count) && (ent_waddr[slot] == ld_waddr)) begin
                for (int b = 0; b < NB; b++) begin
                    if (ent_bv[slot][b]) begin
                        merged[b]   = ent_data[slot][b];
                        from_buf[b] = 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/wbuf_top.sv
// Coalescing store buffer between a store port and a data cache. Stores are
// accepted into entries (word address, data, per-byte valid), drained in
// allocation order over valid/ready, and forwarded to loads byte by byte.
// Assumes: ld_cache_data is the cache word for ld_addr in the same cycle;
// the drain port holds its entry stable until accepted.
module wbuf_top #(
    parameter int DEPTH = wbuf_pkg::WB_DEPTH,
    parameter int AW    = wbuf_pkg::WB_AW,
    parameter int DW    = wbuf_pkg::WB_DW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            st_valid,
    output logic            st_ready,
    input  logic [AW-1:0]   st_addr,
    input  logic [DW-1:0]   st_data,
    input  logic [DW/8-1:0] st_mask,
    input  logic [AW-1:0]   ld_addr,
    input  logic [DW-1:0]   ld_cache_data,
    output logic [DW-1:0]   ld_data,
    output logic [DW/8-1:0] ld_buf_mask,
    output logic            ld_all_buf,
    output logic            dr_valid,
    input  logic            dr_ready,
    output logic [AW-1:0]   dr_addr,
    output logic [DW-1:0]   dr_data,
    output logic [DW/8-1:0] dr_mask
);
    localparam int NB   = DW / 8;
    localparam int OFFW = $clog2(NB);
    localparam int WAW  = AW - OFFW;
    localparam int PTRW = $clog2(DEPTH);
    localparam int CW   = PTRW + 1;

    logic [DEPTH-1:0][WAW-1:0]     ent_waddr;
    logic [DEPTH-1:0][NB-1:0][7:0] ent_data;
    logic [DEPTH-1:0][NB-1:0]      ent_bv;

    logic [PTRW-1:0] head, tail, co_idx;
    logic [CW-1:0]   count;
    logic            co_hit, st_fire, push, pop, full;
    logic [NB-1:0][7:0] st_bytes, merged, cache_bytes;

    assign st_bytes    = st_data;
    assign cache_bytes = ld_cache_data;

    wbuf_order_ctl #(.DEPTH(DEPTH)) u_order (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .head(head), .tail(tail), .count(count)
    );

    wbuf_coalesce_find #(.DEPTH(DEPTH), .WAW(WAW)) u_find (
        .st_waddr(st_addr[AW-1:OFFW]), .ent_waddr(ent_waddr),
        .head(head), .count(count), .hit(co_hit), .idx(co_idx)
    );

    wbuf_load_merge #(.DEPTH(DEPTH), .WAW(WAW), .NB(NB)) u_merge (
        .ld_waddr(ld_addr[AW-1:OFFW]), .cache_data(cache_bytes),
        .ent_waddr(ent_waddr), .ent_data(ent_data), .ent_bv(ent_bv),
        .head(head), .count(count), .merged(merged), .from_buf(ld_buf_mask)
    );

    // Store-side handshake: stall only when full and no merge target.
    assign full     = (count == CW'(DEPTH));
    assign st_ready = !full || co_hit;
    assign st_fire  = st_valid && st_ready;
    assign push     = st_fire && !co_hit;

    // Drain side presents the oldest entry.
    assign dr_valid = (count != '0);
    assign pop      = dr_valid && dr_ready;
    assign dr_addr  = {ent_waddr[head], OFFW'(0)};
    assign dr_data  = ent_data[head];
    assign dr_mask  = ent_bv[head];

    // Load result.
    assign ld_data    = merged;
    assign ld_all_buf = &ld_buf_mask;

    // Entry storage: allocate at tail or merge masked bytes into a match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_waddr <= '0;
            ent_data  <= '0;
            ent_bv    <= '0;
        end else if (st_fire) begin
            if (co_hit) begin
                for (int b = 0; b < NB; b++) begin
                    if (st_mask[b]) begin
                        ent_data[co_idx][b] <= st_bytes[b];
                        ent_bv[co_idx][b]   <= 1'b1;
                    end
                end
            end else begin
                ent_waddr[tail] <= st_addr[AW-1:OFFW];
                ent_data[tail]  <= st_bytes;
                ent_bv[tail]    <= st_mask;
            end
        end
    end
endmodule

// File: rtl/wbuf_chk.sv
// Port-level protocol checker for wbuf_top, attached by bind.
// Assumes: synchronous active-low reset shared with the design.
module wbuf_chk #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            st_valid,
    input logic            st_ready,
    input logic            dr_valid,
    input logic            dr_ready,
    input logic [AW-1:0]   dr_addr,
    input logic [DW-1:0]   dr_data,
    input logic [DW/8-1:0] dr_mask,
    input logic [DW/8-1:0] ld_buf_mask
);
    // R3: an offered entry stays put until the cache takes it.
    p_drain_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dr_valid && !dr_ready |=> dr_valid && $stable(dr_addr)
                                  && $stable(dr_data) && $stable(dr_mask));

    // R2: an accepted store leaves the buffer non-empty next cycle.
    p_store_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid && st_ready |=> dr_valid);

    // R7: the store port only stalls while something is pending.
    p_stall_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !st_ready |-> dr_valid);

    // R8: an empty buffer forwards no byte.
    p_empty_nofwd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !dr_valid |-> ld_buf_mask == '0);
endmodule

bind wbuf_top wbuf_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_addr(dr_addr),
    .dr_data(dr_data), .dr_mask(dr_mask), .ld_buf_mask(ld_buf_mask)
);

// File: tb/sim_wbuf_top.sv
module sim_wbuf_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_valid = 1'b0;
    logic        st_ready;
    logic [31:0] st_addr = '0;
    logic [31:0] st_data = '0;
    logic [3:0]  st_mask = '0;
    logic [31:0] ld_addr = '0;
    logic [31:0] ld_cache_data = '0;
    logic [31:0] ld_data;
    logic [3:0]  ld_buf_mask;
    logic        ld_all_buf;
    logic        dr_valid;
    logic        dr_ready = 1'b0;
    logic [31:0] dr_addr;
    logic [31:0] dr_data;
    logic [3:0]  dr_mask;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wbuf_top u0 (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
        .st_addr(st_addr), .st_data(st_data), .st_mask(st_mask),
        .ld_addr(ld_addr), .ld_cache_data(ld_cache_data), .ld_data(ld_data),
        .ld_buf_mask(ld_buf_mask), .ld_all_buf(ld_all_buf),
        .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_addr(dr_addr),
        .dr_data(dr_data), .dr_mask(dr_mask)
    );

    function automatic logic [31:0] bytes_of(input logic [3:0] m);
        for (int b = 0; b < 4; b++) bytes_of[8*b +: 8] = {8{m[b]}};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Store that must be accepted in its cycle.
    task automatic store(input logic [31:0] a, input logic [31:0] d,
                         input logic [3:0] m);
        @(negedge clk);
        st_addr = a; st_data = d; st_mask = m; st_valid = 1'b1;
        #1 chk(st_ready == 1'b1, "R2 store accepted", {31'b0, st_ready}, 32'd1);
        @(posedge clk);
        #1 st_valid = 1'b0;
    endtask

    // Present a store without letting it complete; check st_ready only.
    task automatic probe(input logic [31:0] a, input logic [3:0] m,
                         input logic exp_rdy, input string req);
        @(negedge clk);
        st_addr = a; st_data = 32'h0; st_mask = m; st_valid = 1'b1;
        #1 chk(st_ready == exp_rdy, req, {31'b0, st_ready}, {31'b0, exp_rdy});
        st_valid = 1'b0;
    endtask

    task automatic load(input logic [31:0] a, input logic [31:0] cache,
                        input logic [31:0] exp_d, input logic [3:0] exp_m,
                        input string req);
        @(negedge clk);
        ld_addr = a; ld_cache_data = cache;
        #1;
        chk(ld_data == exp_d, {req, " data"}, ld_data, exp_d);
        chk(ld_buf_mask == exp_m, {req, " mask"}, {28'b0, ld_buf_mask}, {28'b0, exp_m});
        chk(ld_all_buf == (exp_m == 4'hF), "R10 all-buffer flag",
            {31'b0, ld_all_buf}, {31'b0, exp_m == 4'hF});
    endtask

    task automatic drain(input logic [31:0] a, input logic [31:0] d,
                         input logic [3:0] m);
        @(negedge clk);
        #1;
        chk(dr_valid == 1'b1, "R3 drain valid", {31'b0, dr_valid}, 32'd1);
        chk(dr_addr == a, "R3 drain order addr", dr_addr, a);
        chk(dr_mask == m, "R3 drain mask", {28'b0, dr_mask}, {28'b0, m});
        chk((dr_data & bytes_of(m)) == (d & bytes_of(m)), "R3 drain data",
            dr_data & bytes_of(m), d & bytes_of(m));
        dr_ready = 1'b1;
        @(posedge clk);
        #1 dr_ready = 1'b0;
    endtask

    task automatic expect_empty(input string req);
        @(negedge clk);
        #1 chk(dr_valid == 1'b0, req, {31'b0, dr_valid}, 32'd0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        chk(dr_valid == 1'b0, "R1 reset drain idle", {31'b0, dr_valid}, 32'd0);
        chk(st_ready == 1'b1, "R1 reset store ready", {31'b0, st_ready}, 32'd1);
        load(32'h100, 32'h12345678, 32'h12345678, 4'h0, "R1 reset no forward");
    endtask

    task automatic t_partial;
        // R11: store in flight is not yet visible to a load in its own cycle.
        @(negedge clk);
        st_addr = 32'h100; st_data = 32'hAABBCCDD; st_mask = 4'b0101; st_valid = 1'b1;
        ld_addr = 32'h100; ld_cache_data = 32'h11223344;
        #1 chk(ld_buf_mask == 4'h0, "R11 same-cycle invisible", {28'b0, ld_buf_mask}, 32'd0);
        @(posedge clk);
        #1 st_valid = 1'b0;
        load(32'h102, 32'h11223344, 32'h11BB33DD, 4'b0101, "R8 partial merge");
        load(32'h104, 32'h55667788, 32'h55667788, 4'h0, "R8 other word from cache");
    endtask

    task automatic t_coalesce;
        store(32'h104, 32'h00001122, 4'b0011);
        store(32'h104, 32'h33440000, 4'b1100);
        load(32'h104, 32'hFFFFFFFF, 32'h33441122, 4'hF, "R5 merged word");
        drain(32'h100, 32'hAABBCCDD, 4'b0101);
        drain(32'h104, 32'h33441122, 4'hF);
        expect_empty("R5 two stores left one entry");
        load(32'h104, 32'h01010101, 32'h01010101, 4'h0, "R11 drained entry gone");
    endtask

    task automatic t_head_no_merge;
        store(32'h300, 32'h00000055, 4'b0001);
        store(32'h300, 32'h00006600, 4'b0010);
        load(32'h300, 32'h0, 32'h00006655, 4'b0011, "R8 two entries merged");
        drain(32'h300, 32'h00000055, 4'b0001);
        drain(32'h300, 32'h00006600, 4'b0010);
        expect_empty("R6 head store allocated separately");
    endtask

    task automatic t_youngest;
        store(32'h400, 32'h01020304, 4'hF);
        store(32'h400, 32'h000000AA, 4'b0001);
        load(32'h400, 32'h0, 32'h010203AA, 4'hF, "R9 youngest byte wins");
        store(32'h400, 32'h0000BB00, 4'b0010);
        load(32'h400, 32'h0, 32'h0102BBAA, 4'hF, "R9 merge into youngest");
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1 chk(dr_valid && dr_addr == 32'h400 && dr_mask == 4'hF,
               "R3 drain held while not ready", dr_addr, 32'h400);
        drain(32'h400, 32'h01020304, 4'hF);
        drain(32'h400, 32'h0000BBAA, 4'b0011);
        expect_empty("R3 buffer empty after drain");
    endtask

    task automatic t_full;
        store(32'h500, 32'h50505050, 4'hF);
        store(32'h504, 32'h54545454, 4'hF);
        store(32'h508, 32'h58585858, 4'b0001);
        store(32'h50C, 32'h5C5C5C5C, 4'hF);
        probe(32'h510, 4'hF, 1'b0, "R7 full stalls new word");
        repeat (4) @(posedge clk);
        probe(32'h510, 4'hF, 1'b0, "R4 no release without ready");
        probe(32'h500, 4'hF, 1'b0, "R6 full head word stalls");
        store(32'h508, 32'h00009900, 4'b0010);
        drain(32'h500, 32'h50505050, 4'hF);
        store(32'h510, 32'h60606060, 4'hF);
        drain(32'h504, 32'h54545454, 4'hF);
        drain(32'h508, 32'h00009958, 4'b0011);
        drain(32'h50C, 32'h5C5C5C5C, 4'hF);
        drain(32'h510, 32'h60606060, 4'hF);
        expect_empty("R4 all released after acceptance");
    endtask

    initial begin
        t_reset();
        t_partial();
        t_coalesce();
        t_head_no_merge();
        t_youngest();
        t_full();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule